// File: doc/BRIEF.md
# Debug Register Scan Access

This block is the data-register side of a debug scan chain. It sits behind a TAP controller that has already decoded its states. On each test-clock edge it acts on three strobes: capture, shift and update. A chain-select input qualifies all three. Each scan moves a 38-bit frame through a shift register, least significant bit first. The frame holds a 32-bit data word, a 5-bit register address and a write flag.

On update, the frame either writes its data word into the addressed debug register, or it only records the address. A recorded address selects the register whose contents the next scan's capture loads. A read therefore takes two scans: the first names the register and the second brings out its value. Capturing the communications data register consumes it. The block reports each such capture on a one-cycle strobe. A host that wants a clean read of that register re-points the address at the communications control register on the final scan, because capturing the control register has no side effect.

The register bank is internal. Its contents are visible on a flat output bus, and every accepted write is reported on a write port so the neighbouring logic can follow the bank. There is no state machine: capture, shift and update act directly on the shift register, and they are mutually exclusive in that order of priority. The names idle, capture, shift and update in this brief refer to those strobes.

Top module: `dbg_scan_access`

## Requirements
- R1: The frame is decoded from the shift register on update with bits 31:0 as data, bits 36:32 as register address, and bit 37 as the write flag (1 = write, 0 = read).
- R2: An update with the write flag set stores the frame data, masked to the register's implemented bits, into the addressed register. In that same edge it raises `wr_stb` for one cycle, with `wr_addr` and the stored value on `wr_data`.
- R3: An update with the write flag clear only records the address for the next capture. It changes no register and raises no `wr_stb`.
- R4: A capture loads the recorded register's value into frame bits 31:0 and zeros into bits 37:32.
- R5: Each shift edge moves `tdi` into bit 37 and every other bit one place toward bit 0. `tdo` always shows bit 0, so the frame leaves LSB first.
- R6: A capture while the recorded address equals the communications data address (default 5) pulses `rd_consume` for one cycle after that edge. Each such capture pulses again. A capture at any other address, including the communications control address (default 4), does not pulse.
- R7: Bits above a register's implemented width read as zero. The default widths for addresses 0 to 7 are 6, 5, 8, 32, 32, 32, 32 and 32.
- R8: Addresses at or above the register count (default 8) read as zero. Writes to them change nothing and raise no `wr_stb`.
- R9: After reset, all registers and the shift register are zero, `tdo`, `wr_stb` and `rd_consume` are low, and the recorded address is the communications control address.
- R10: While `sel` is low, the capture, shift and update strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; everything updates on its rising edge |
| trst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | This chain is selected |
| capture_dr | input | 1 | Capture strobe from the TAP |
| shift_dr | input | 1 | Shift strobe from the TAP |
| update_dr | input | 1 | Update strobe from the TAP |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (frame bit 0) |
| bank_q | output | NUM_REGS*32 | Register contents, register i at bits i*32 upward |
| wr_stb | output | 1 | One-cycle pulse per accepted write |
| wr_addr | output | 5 | Address of the accepted write |
| wr_data | output | 32 | Masked value stored by the accepted write |
| rd_consume | output | 1 | One-cycle pulse per capture of the communications data register |

## Verification
Every result lands one edge after its strobe. The captured word is at `tdo` bit 0 right after the capture edge, and each later bit follows one shift edge after the one before. `rd_consume` is high in the cycle after the capture edge. `wr_stb`, `wr_addr`, `wr_data` and `bank_q` reflect an update from the edge that accepted it. The bench drives strobes on falling edges and reads results on the following falling edge, so each check falls exactly in the cycle when its result is due. It sweeps all 32 addresses with a write, a read-address scan and a follow-up capture scan, and it computes each expected value from the width table and the data pattern.

// File: rtl/dbgscan_pkg.sv
`timescale 1ns/1ps
package dbgscan_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 5;
    localparam int FRAME_W = DATA_W + ADDR_W + 1;
    localparam int WBITS_W = 6;

    // Field order is behaviour: MSB is the write flag, then address, then data.
    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } scan_frame_t;
endpackage

// File: rtl/dbg_scan_shifter.sv
`timescale 1ns/1ps
module dbg_scan_shifter
    import dbgscan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              shift_en,
    input  logic              tdi,
    input  logic [DATA_W-1:0] cap_word,
    output scan_frame_t       frame_q,
    output logic              tdo
);
    logic [FRAME_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (cap_en) begin
            sh_q <= {{(FRAME_W-DATA_W){1'b0}}, cap_word};
        end else if (shift_en) begin
            sh_q <= {tdi, sh_q[FRAME_W-1:1]};
        end
    end

    assign frame_q = scan_frame_t'(sh_q);
    assign tdo     = sh_q[0];
endmodule

// File: rtl/dbg_scan_rdptr.sv
`timescale 1ns/1ps
module dbg_scan_rdptr
    import dbgscan_pkg::*;
#(
    parameter int CTRL_ADDR = 4,
    parameter int DATA_ADDR = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              cap_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              consume
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_addr <= CTRL_A;
        end else if (set_en) begin
            rd_addr <= addr_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            consume <= 1'b0;
        end else begin
            consume <= cap_en && (rd_addr == DATA_A);
        end
    end
endmodule

// File: rtl/dbg_scan_regbank.sv
`timescale 1ns/1ps
module dbg_scan_regbank
    import dbgscan_pkg::*;
#(
    parameter int                          NUM_REGS = 8,
    parameter logic [NUM_REGS*WBITS_W-1:0] REG_BITS = {6'd32, 6'd32, 6'd32, 6'd32,
                                                       6'd32, 6'd8, 6'd5, 6'd6}
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [ADDR_W-1:0]          waddr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [ADDR_W-1:0]          raddr,
    output logic [DATA_W-1:0]          rdata,
    output logic [NUM_REGS*DATA_W-1:0] bank_flat,
    output logic                       wr_stb,
    output logic [ADDR_W-1:0]          wr_addr,
    output logic [DATA_W-1:0]          wr_data
);
    logic [DATA_W-1:0] regs  [NUM_REGS];
    logic [DATA_W-1:0] masks [NUM_REGS];
    logic [DATA_W-1:0] wmask;
    logic              wmapped;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam int             W = int'(REG_BITS[g*WBITS_W +: WBITS_W]);
        localparam logic [DATA_W-1:0] M =
            (W >= DATA_W) ? {DATA_W{1'b1}} : ((DATA_W'(1) << W) - DATA_W'(1));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (we && waddr == ADDR_W'(g)) begin
                regs[g] <= wdata & M;
            end
        end

        assign masks[g]                    = M;
        assign bank_flat[g*DATA_W +: DATA_W] = regs[g];
    end

    always_comb begin
        wmask   = '0;
        wmapped = 1'b0;
        rdata   = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (waddr == ADDR_W'(i)) begin
                wmask   = masks[i];
                wmapped = 1'b1;
            end
            if (raddr == ADDR_W'(i)) begin
                rdata = regs[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= we && wmapped;
            if (we && wmapped) begin
                wr_addr <= waddr;
                wr_data <= wdata & wmask;
            end
        end
    end
endmodule

// File: rtl/dbg_scan_access.sv
`timescale 1ns/1ps
module dbg_scan_access
    import dbgscan_pkg::*;
#(
    parameter int                          NUM_REGS  = 8,
    parameter int                          CTRL_ADDR = 4,
    parameter int                          DATA_ADDR = 5,
    parameter logic [NUM_REGS*WBITS_W-1:0] REG_BITS  = {6'd32, 6'd32, 6'd32, 6'd32,
                                                        6'd32, 6'd8, 6'd5, 6'd6}
) (
    input  logic                       tck,
    input  logic                       trst_n,
    input  logic                       sel,
    input  logic                       capture_dr,
    input  logic                       shift_dr,
    input  logic                       update_dr,
    input  logic                       tdi,
    output logic                       tdo,
    output logic [NUM_REGS*DATA_W-1:0] bank_q,
    output logic                       wr_stb,
    output logic [ADDR_W-1:0]          wr_addr,
    output logic [DATA_W-1:0]          wr_data,
    output logic                       rd_consume
);
    scan_frame_t       frame_q;
    logic              cap_en, shift_en, upd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_word;
    logic [5:0]        sh_hi;

    // Strobe priority: capture, then shift, then update.
    assign cap_en   = sel && capture_dr;
    assign shift_en = sel && shift_dr && !capture_dr;
    assign upd_en   = sel && update_dr && !capture_dr && !shift_dr;
    assign sh_hi    = {frame_q.wr, frame_q.addr};

    dbg_scan_shifter u_shift (
        .clk      (tck),
        .rst_n    (trst_n),
        .cap_en   (cap_en),
        .shift_en (shift_en),
        .tdi      (tdi),
        .cap_word (rd_word),
        .frame_q  (frame_q),
        .tdo      (tdo)
    );

    dbg_scan_rdptr #(
        .CTRL_ADDR (CTRL_ADDR),
        .DATA_ADDR (DATA_ADDR)
    ) u_ptr (
        .clk     (tck),
        .rst_n   (trst_n),
        .set_en  (upd_en && !frame_q.wr),
        .addr_in (frame_q.addr),
        .cap_en  (cap_en),
        .rd_addr (rd_addr),
        .consume (rd_consume)
    );

    dbg_scan_regbank #(
        .NUM_REGS (NUM_REGS),
        .REG_BITS (REG_BITS)
    ) u_bank (
        .clk       (tck),
        .rst_n     (trst_n),
        .we        (upd_en && frame_q.wr),
        .waddr     (frame_q.addr),
        .wdata     (frame_q.data),
        .raddr     (rd_addr),
        .rdata     (rd_word),
        .bank_flat (bank_q),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );
endmodule

// File: rtl/dbg_scan_checker.sv
`timescale 1ns/1ps
module dbg_scan_checker #(
    parameter int NUM_REGS = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   sel,
    input logic                   capture_dr,
    input logic                   shift_dr,
    input logic                   update_dr,
    input logic                   tdo,
    input logic [NUM_REGS*32-1:0] bank_q,
    input logic                   wr_stb,
    input logic [4:0]             wr_addr,
    input logic                   rd_consume,
    input logic [5:0]             sh_hi
);
    a_r2_stb_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(sel && update_dr && sh_hi[5]));

    a_r3_read_keeps_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && update_dr && !capture_dr && !shift_dr && !sh_hi[5])
        |=> ($stable(bank_q) && !wr_stb));

    a_r4_capture_clears_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && capture_dr) |=> (sh_hi == 6'd0));

    a_r6_consume_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
        rd_consume |-> $past(sel && capture_dr));

    a_r8_stb_only_mapped: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (int'(wr_addr) < NUM_REGS));

    a_r10_deselected_inert: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> ($stable(tdo) && !wr_stb && !rd_consume));
endmodule

bind dbg_scan_access dbg_scan_checker #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk        (tck),
    .rst_n      (trst_n),
    .sel        (sel),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .update_dr  (update_dr),
    .tdo        (tdo),
    .bank_q     (bank_q),
    .wr_stb     (wr_stb),
    .wr_addr    (wr_addr),
    .rd_consume (rd_consume),
    .sh_hi      (sh_hi)
);

// File: tb/sim_dbg_scan_access.sv
`timescale 1ns/1ps
module sim_dbg_scan_access;
    logic         tck = 1'b0;
    logic         trst_n = 1'b0;
    logic         sel = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
    logic         tdo;
    logic [255:0] bank_q;
    logic         wr_stb;
    logic [4:0]   wr_addr;
    logic [31:0]  wr_data;
    logic         rd_consume;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [31:0] model [8];

    always #10 tck = ~tck;

    dbg_scan_access u0 (
        .tck(tck), .trst_n(trst_n), .sel(sel), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
        .bank_q(bank_q), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_consume(rd_consume)
    );

    function automatic logic [31:0] mask_of(input int a);
        int w;
        case (a)
            0: w = 6;
            1: w = 5;
            2: w = 8;
            3, 4, 5, 6, 7: w = 32;
            default: w = 0;
        endcase
        if (w >= 32) return 32'hFFFF_FFFF;
        return (32'd1 << w) - 32'd1;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One full scan: capture, 38 shifts, update. Returns bits seen on tdo,
    // the consume strobe after capture, and write-port values after update.
    task automatic do_scan(input logic [37:0] fr, input logic s,
                           output logic [37:0] seen, output logic cons,
                           output logic stb, output logic [4:0] wa,
                           output logic [31:0] wd);
        @(negedge tck);
        sel = s; capture_dr = 1'b1;
        @(negedge tck);
        capture_dr = 1'b0;
        cons = rd_consume;
        shift_dr = 1'b1;
        for (int i = 0; i < 38; i++) begin
            seen[i] = tdo;
            tdi = fr[i];
            @(negedge tck);
        end
        shift_dr = 1'b0; update_dr = 1'b1;
        @(negedge tck);
        update_dr = 1'b0; sel = 1'b0;
        stb = wr_stb; wa = wr_addr; wd = wr_data;
    endtask

    function automatic logic [31:0] pat(input int a);
        return 32'hF0E1_D2C3 ^ (32'(a) * 32'h0001_0203);
    endfunction

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [37:0] seen;
        logic        cons, stb;
        logic [4:0]  wa;
        logic [31:0] wd;
        logic [31:0] expv;

        for (int i = 0; i < 8; i++) model[i] = '0;
        repeat (3) @(negedge tck);
        // R9: reset state
        chk("R9 tdo", 64'(tdo), 0);
        chk("R9 wr_stb", 64'(wr_stb), 0);
        chk("R9 rd_consume", 64'(rd_consume), 0);
        chk("R9 bank", 64'(bank_q[63:0]), 0);
        trst_n = 1'b1;
        repeat (2) @(negedge tck);

        // R9: pointer starts at control register (addr 4): write it, then capture it.
        do_scan({1'b1, 5'd4, 32'h1234_5678}, 1'b1, seen, cons, stb, wa, wd);
        model[4] = 32'h1234_5678;
        chk("R9 first capture", 64'(seen), 0);
        chk("R9 no consume at ctrl", 64'(cons), 0);
        do_scan({1'b0, 5'd4, 32'h0}, 1'b1, seen, cons, stb, wa, wd);
        chk("R9 ptr at ctrl", 64'(seen), 64'({6'd0, 32'h1234_5678}));

        // Sweep all addresses: R1 R2 R3 R4 R5 R7 R8 R6
        for (int a = 0; a < 32; a++) begin
            logic mapped;
            mapped = (a < 8);
            expv = pat(a) & mask_of(a);
            do_scan({1'b1, 5'(a), pat(a)}, 1'b1, seen, cons, stb, wa, wd);
            if (mapped) model[a] = expv;
            chk("R2 R8 wr_stb", 64'(stb), 64'(mapped));
            if (mapped) begin
                chk("R2 R1 wr_addr", 64'(wa), 64'(a));
                chk("R2 R7 wr_data", 64'(wd), 64'(expv));
            end
            for (int k = 0; k < 8; k++)
                chk("R2 R8 bank", 64'(bank_q[k*32 +: 32]), 64'(model[k]));
            // R3: read-address scan changes nothing
            do_scan({1'b0, 5'(a), ~pat(a)}, 1'b1, seen, cons, stb, wa, wd);
            chk("R3 no wr_stb", 64'(stb), 0);
            for (int k = 0; k < 8; k++)
                chk("R3 bank kept", 64'(bank_q[k*32 +: 32]), 64'(model[k]));
            // R4 R5 R7 R8 R6: next capture returns the register, LSB first
            do_scan({1'b0, 5'd4, 32'h0}, 1'b1, seen, cons, stb, wa, wd);
            chk("R4 R5 R7 R8 captured", 64'(seen), 64'({6'd0, mapped ? expv : 32'h0}));
            chk("R6 consume", 64'(cons), 64'(a == 5));
        end

        // R6: a pointer left at the data register consumes on every capture
        do_scan({1'b0, 5'd5, 32'h0}, 1'b1, seen, cons, stb, wa, wd);
        chk("R6 ctrl no consume", 64'(cons), 0);
        do_scan({1'b0, 5'd5, 32'h0}, 1'b1, seen, cons, stb, wa, wd);
        chk("R6 first consume", 64'(cons), 1);
        do_scan({1'b0, 5'd4, 32'h0}, 1'b1, seen, cons, stb, wa, wd);
        chk("R6 second consume", 64'(cons), 1);
        chk("R6 data value", 64'(seen), 64'({6'd0, model[5]}));
        do_scan({1'b0, 5'd4, 32'h0}, 1'b1, seen, cons, stb, wa, wd);
        chk("R6 ctrl safe", 64'(cons), 0);

        // R10: a deselected write scan does nothing; tdo holds
        do_scan({1'b1, 5'd3, 32'h0BAD_F00D}, 1'b0, seen, cons, stb, wa, wd);
        chk("R10 no wr_stb", 64'(stb), 0);
        chk("R10 no consume", 64'(cons), 0);
        chk("R10 tdo held", 64'(seen), {26'd0, {38{seen[0]}}});
        for (int k = 0; k < 8; k++)
            chk("R10 bank kept", 64'(bank_q[k*32 +: 32]), 64'(model[k]));
        do_scan({1'b0, 5'd3, 32'h0}, 1'b1, seen, cons, stb, wa, wd);
        do_scan({1'b0, 5'd4, 32'h0}, 1'b1, seen, cons, stb, wa, wd);
        chk("R10 reg3 unchanged", 64'(seen), 64'({6'd0, model[3]}));

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule